// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This controller manages power for a small microcontroller core. While the core runs, a sleep strobe captures a 3-bit mode code. The code selects which clock domains stop: the CPU, the flash, the I/O domain and the oscillator. The controller then waits for a wake-up event from one of several classes, and lets the CPU clock resume only after a delay that depends on whether the oscillator kept running.

The block is clocked by an always-on timebase, which is not gated by the enables it drives. A per-peripheral gating register is also part of the block. Setting a bit in it freezes that peripheral's clock and refuses register accesses to that peripheral. A level-type wake source counts only after it has stayed active for a minimum number of cycles.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en`, `flash_clk_en`, `io_clk_en` and `osc_en` are 1, `wake_pulse` is 0, and every bit of the gating register is clear, so all of `periph_clk_en` is 1.
- R2: Mode 000 is idle, and the reserved codes 001, 100 and 101 act as idle. Idle stops only the CPU and flash clocks. Any wake class wakes it, including `wake_sync`, and `cpu_clk_en` is 1 right after the edge that accepts the event.
- R3: Modes 010 (power-down) and 011 (power-save) stop all four clocks. `wake_sync` is ignored in these modes.
- R4: With `xtal_sel`=1, modes 110 and 111 stop the CPU, flash and I/O clocks, keep `osc_en` at 1, and ignore `wake_sync`. With `xtal_sel`=0, these two modes behave as power-down.
- R5: In the deep modes (all modes except idle), a wake is accepted only from `wake_async`, `wake_rst` or a qualified `wake_level`.
- R6: Waking from standby releases `cpu_clk_en` on the STBY_CYC-th edge (default 6) after the accepting edge. The CPU, flash and I/O clocks stay off until then.
- R7: Waking from power-down raises `osc_en` at the accepting edge. `cpu_clk_en` is released 2^(DLY_LOG+2*dly_sel) edges later, which with the default is 16, 64, 256 or 1024 edges for `dly_sel` 0 to 3.
- R8: `wake_level` is accepted only on the LVL_HOLD-th consecutive edge (default 4) at which it is 1. A shorter pulse has no effect.
- R9: `sleep_req` is acted on only while the CPU clock runs, and the mode code is captured at that edge. A request made while asleep or waking is ignored.
- R10: `wake_pulse` is 1 for exactly one cycle, in the first cycle after a wake in which `cpu_clk_en` is 1 again.
- R11: `prr_we` loads `prr_wdata` only while the CPU clock runs. `periph_clk_en[i]` is 1 only when bit i is clear and `io_clk_en` is 1.
- R12: `acc_ok[i]` equals `acc_req[i]` while gating bit i is clear, and is 0 while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on timebase |
| rst_n | input | 1 | active-low reset |
| sleep_mode | input | 3 | sleep mode code |
| sleep_req | input | 1 | sleep strobe from the CPU |
| xtal_sel | input | 1 | external crystal clock option configured |
| dly_sel | input | 2 | start-up delay select |
| wake_sync | input | 1 | internal interrupt (timer, serial, USB) |
| wake_async | input | 1 | asynchronous event: pin change, lines 3..0, two-wire address match, USB resume |
| wake_level | input | 1 | level interrupt on lines 7..4 |
| wake_rst | input | 1 | external, watchdog or brown-out reset request |
| prr_we | input | 1 | gating register write strobe |
| prr_wdata | input | NPER | gating register write data |
| acc_req | input | NPER | per-peripheral register access request |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| osc_en | output | 1 | oscillator enable |
| wake_pulse | output | 1 | one-cycle wake indication |
| periph_clk_en | output | NPER | per-peripheral clock enables |
| acc_ok | output | NPER | per-peripheral access grant |

## Verification
The clock enables are decoded from registered state. They change on the same edge that samples `sleep_req`, or the edge that accepts a wake, and `wake_pulse` appears in the first cycle after that release. `acc_ok` is combinational and follows `acc_req` within the same cycle. A behavioural model in the bench advances on each rising edge, and every output is compared half a cycle later, after the inputs have settled. Wake latency is measured by counting falling edges from the moment a stimulus is driven until `cpu_clk_en` returns. The count is compared with 1 for idle, STBY_CYC+1 for standby, and 2^(DLY_LOG+2*dly_sel)+1 for power-down. A level source adds LVL_HOLD-1 to each of these.

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl #(
  parameter int NPER     = 8,
  parameter int LVL_HOLD = 4,
  parameter int STBY_CYC = 6,
  parameter int DLY_LOG  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      sleep_mode,
  input  logic            sleep_req,
  input  logic            xtal_sel,
  input  logic [1:0]      dly_sel,
  input  logic            wake_sync,
  input  logic            wake_async,
  input  logic            wake_level,
  input  logic            wake_rst,
  input  logic            prr_we,
  input  logic [NPER-1:0] prr_wdata,
  input  logic [NPER-1:0] acc_req,
  output logic            cpu_clk_en,
  output logic            flash_clk_en,
  output logic            io_clk_en,
  output logic            osc_en,
  output logic            wake_pulse,
  output logic [NPER-1:0] periph_clk_en,
  output logic [NPER-1:0] acc_ok
);

  localparam int CW = DLY_LOG + 6;
  localparam int LW = $clog2(LVL_HOLD + 1);

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_WAKE} st_t;
  typedef enum logic [1:0] {C_IDLE, C_PD, C_STBY} cls_t;

  st_t             st;
  cls_t            cls, req_cls;
  logic [CW-1:0]   cnt, pd_len;
  logic [LW-1:0]   lvl_cnt;
  logic [NPER-1:0] prr_q;
  logic            lvl_ok, deep_wake, accept;

  always_comb begin
    case (sleep_mode)
      3'b010, 3'b011: req_cls = C_PD;
      3'b110, 3'b111: req_cls = xtal_sel ? C_STBY : C_PD;
      default:        req_cls = C_IDLE;
    endcase
  end

  assign pd_len    = CW'((1 << (DLY_LOG + 2 * int'(dly_sel))) - 1);
  assign lvl_ok    = wake_level && (lvl_cnt >= LW'(LVL_HOLD - 1));
  assign deep_wake = wake_async | wake_rst | lvl_ok;
  assign accept    = (cls == C_IDLE) ? (deep_wake | wake_sync) : deep_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cls        <= C_IDLE;
      cnt        <= '0;
      lvl_cnt    <= '0;
      prr_q      <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      if (!wake_level)                 lvl_cnt <= '0;
      else if (lvl_cnt < LW'(LVL_HOLD)) lvl_cnt <= lvl_cnt + 1'b1;
      if (st == S_RUN && prr_we) prr_q <= prr_wdata;
      case (st)
        S_RUN: if (sleep_req) begin
          st  <= S_SLEEP;
          cls <= req_cls;
        end
        S_SLEEP: if (accept) begin
          if (cls == C_IDLE) begin
            st         <= S_RUN;
            wake_pulse <= 1'b1;
          end else begin
            st  <= S_WAKE;
            cnt <= (cls == C_STBY) ? CW'(STBY_CYC - 1) : pd_len;
          end
        end
        S_WAKE: if (cnt == '0) begin
          st         <= S_RUN;
          wake_pulse <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en    = (st == S_RUN);
  assign flash_clk_en  = (st == S_RUN);
  assign io_clk_en     = (st == S_RUN) || (st == S_SLEEP && cls == C_IDLE);
  assign osc_en        = !(st == S_SLEEP && cls == C_PD);
  assign periph_clk_en = ~prr_q & {NPER{io_clk_en}};
  assign acc_ok        = acc_req & ~prr_q;

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk #(parameter int NPER = 8) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_req,
  input logic            cpu_clk_en,
  input logic            io_clk_en,
  input logic            osc_en,
  input logic            wake_pulse,
  input logic [NPER-1:0] prr
);
  // R4
  osc_off_io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !io_clk_en);
  // R7
  osc_restart_cpu_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |=> !cpu_clk_en);
  // R9
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && cpu_clk_en) |=> !cpu_clk_en);
  // R10
  pulse_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_pulse);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R11
  prr_frozen_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |=> $stable(prr));
endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk #(.NPER(NPER)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cpu_clk_en(cpu_clk_en),
  .io_clk_en(io_clk_en), .osc_en(osc_en), .wake_pulse(wake_pulse), .prr(prr_q)
);

// File: tb/sleep_clk_ctrl_tb.sv
module sleep_clk_ctrl_tb;
  localparam int NPER = 8, LVL_HOLD = 4, STBY_CYC = 6, DLY_LOG = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] sleep_mode = 0;
  logic sleep_req = 0, xtal_sel = 1;
  logic [1:0] dly_sel = 0;
  logic wake_sync = 0, wake_async = 0, wake_level = 0, wake_rst = 0, prr_we = 0;
  logic [NPER-1:0] prr_wdata = 0, acc_req = 0;
  logic cpu_clk_en, flash_clk_en, io_clk_en, osc_en, wake_pulse;
  logic [NPER-1:0] periph_clk_en, acc_ok;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sleep_clk_ctrl #(.NPER(NPER), .LVL_HOLD(LVL_HOLD), .STBY_CYC(STBY_CYC), .DLY_LOG(DLY_LOG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .sleep_req(sleep_req), .xtal_sel(xtal_sel),
    .dly_sel(dly_sel), .wake_sync(wake_sync), .wake_async(wake_async), .wake_level(wake_level),
    .wake_rst(wake_rst), .prr_we(prr_we), .prr_wdata(prr_wdata), .acc_req(acc_req),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en), .osc_en(osc_en),
    .wake_pulse(wake_pulse), .periph_clk_en(periph_clk_en), .acc_ok(acc_ok));

  // reference model: 0 run, 1 asleep, 2 starting; class 0 idle, 1 power-down, 2 standby
  int m_st = 0, m_cls = 0, m_left = 0, m_lvl = 0;
  bit m_pulse = 0;
  logic [NPER-1:0] m_prr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cls = 0; m_left = 0; m_lvl = 0; m_pulse = 0; m_prr = 0;
    end else begin
      bit lvl_q, any_deep;
      lvl_q = wake_level && (m_lvl + 1 >= LVL_HOLD);
      m_lvl = wake_level ? m_lvl + 1 : 0;
      any_deep = wake_async || wake_rst || lvl_q;
      m_pulse = 0;
      if (m_st == 0) begin
        if (prr_we) m_prr = prr_wdata;
        if (sleep_req) begin
          m_st = 1;
          if (sleep_mode == 3'b010 || sleep_mode == 3'b011) m_cls = 1;
          else if (sleep_mode[2:1] == 2'b11) m_cls = xtal_sel ? 2 : 1;
          else m_cls = 0;
        end
      end else if (m_st == 1) begin
        if (m_cls == 0 && (any_deep || wake_sync)) begin
          m_st = 0; m_pulse = 1;
        end else if (m_cls != 0 && any_deep) begin
          m_st = 2;
          m_left = (m_cls == 2) ? STBY_CYC : (1 << (DLY_LOG + 2 * int'(dly_sel)));
        end
      end else begin
        m_left--;
        if (m_left == 0) begin m_st = 0; m_pulse = 1; end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit e_run, e_io, e_osc;
      e_run = (m_st == 0);
      e_io  = e_run || (m_st == 1 && m_cls == 0);
      e_osc = !(m_st == 1 && m_cls == 1);
      chk(cpu_clk_en == e_run && flash_clk_en == e_run, "R2/R3/R4 cpu+flash enable",
          {cpu_clk_en, flash_clk_en}, {e_run, e_run});
      chk(io_clk_en == e_io, "R2/R3/R4 io enable", io_clk_en, e_io);
      chk(osc_en == e_osc, "R3/R4/R7 osc enable", osc_en, e_osc);
      chk(wake_pulse == m_pulse, "R10 wake pulse", wake_pulse, m_pulse);
      chk(periph_clk_en == (~m_prr & {NPER{e_io}}), "R11 periph enable",
          periph_clk_en, ~m_prr & {NPER{e_io}});
      chk(acc_ok == (acc_req & ~m_prr), "R12 access grant", acc_ok, acc_req & ~m_prr);
    end
  end

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  task automatic go_sleep(logic [2:0] mode, logic x);
    @(negedge clk);
    sleep_mode = mode; xtal_sel = x; sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
  endtask

  // kind: 0 sync, 1 async, 2 level, 3 reset request
  task automatic wake_measure(int kind, int exp, string req);
    int n = 0;
    @(negedge clk);
    case (kind)
      0: wake_sync = 1;
      1: wake_async = 1;
      2: wake_level = 1;
      default: wake_rst = 1;
    endcase
    do begin
      @(negedge clk); #1; n++;
      wake_sync = 0; wake_async = 0; wake_rst = 0;
    end while (!cpu_clk_en && n < 3000);
    wake_level = 0;
    chk(n == exp, req, n, exp);
  endtask

  task automatic ignored(int kind, string req);
    @(negedge clk);
    if (kind == 0) wake_sync = 1; else wake_level = 1;
    repeat (kind == 0 ? 1 : LVL_HOLD - 1) @(negedge clk);
    wake_sync = 0; wake_level = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(!cpu_clk_en, req, cpu_clk_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk({cpu_clk_en, flash_clk_en, io_clk_en, osc_en, wake_pulse} == 5'b11110, "R1 reset enables",
        {cpu_clk_en, flash_clk_en, io_clk_en, osc_en, wake_pulse}, 5'b11110);
    chk(periph_clk_en == '1, "R1 reset periph", periph_clk_en, '1);
    rst_n = 1;

    // R11 and R12: gating register
    @(negedge clk); prr_we = 1; prr_wdata = 8'h05; acc_req = 8'hFF;
    @(negedge clk); prr_we = 0; #1;
    chk(periph_clk_en == 8'hFA, "R11 gated periph", periph_clk_en, 8'hFA);
    chk(acc_ok == 8'hFA, "R12 blocked access", acc_ok, 8'hFA);

    // R2 idle and reserved codes wake on internal interrupt
    foreach (m_prr[i]) begin end
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 1 || c == 4 || c == 5) begin
        go_sleep(3'(c), 1);
        wake_measure(0, 1, "R2 idle wake latency");
      end
    end

    // R11 write while asleep ignored; R9 sleep request while asleep ignored
    go_sleep(3'b000, 1);
    @(negedge clk); prr_we = 1; prr_wdata = 8'h00; sleep_mode = 3'b010; sleep_req = 1;
    @(negedge clk); prr_we = 0; sleep_req = 0; #1;
    chk(periph_clk_en == 8'hFA, "R11 write while asleep", periph_clk_en, 8'hFA);
    chk(io_clk_en == 1, "R9 request while asleep", io_clk_en, 1);
    wake_measure(1, 1, "R2 idle async wake");

    // R3 power-down and power-save
    go_sleep(3'b010, 1);
    ignored(0, "R3 power-down ignores internal");
    wake_measure(1, 17, "R7 power-down latency dly0");
    go_sleep(3'b011, 1);
    ignored(0, "R3 power-save ignores internal");
    wake_measure(3, 17, "R5 reset request wake");

    // R4 and R6 standby with crystal
    go_sleep(3'b110, 1);
    ignored(0, "R4 standby ignores internal");
    wake_measure(1, STBY_CYC + 1, "R6 standby latency");
    go_sleep(3'b111, 1);
    wake_measure(1, STBY_CYC + 1, "R6 extended standby latency");

    // R4 without crystal acts as power-down
    go_sleep(3'b110, 0);
    @(negedge clk); #1;
    chk(osc_en == 0, "R4 no crystal osc off", osc_en, 0);
    wake_measure(1, 17, "R4 no crystal latency");

    // R7 delay select
    for (int d = 1; d < 4; d++) begin
      dly_sel = 2'(d);
      go_sleep(3'b010, 1);
      wake_measure(1, (1 << (DLY_LOG + 2 * d)) + 1, "R7 power-down latency");
    end
    dly_sel = 0;

    // R8 level qualification
    go_sleep(3'b010, 1);
    ignored(1, "R8 short level ignored");
    wake_measure(2, LVL_HOLD - 1 + 17, "R8 held level wake");

    // R12 clear gating
    @(negedge clk); prr_we = 1; prr_wdata = 8'h80; acc_req = 8'hC3;
    @(negedge clk); prr_we = 0; #1;
    chk(acc_ok == 8'h43, "R12 access after clear", acc_ok, 8'h43);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule